// File: doc/BRIEF.md
# Escape-Instruction Queue Mirror

This block lets a numeric coprocessor follow the host CPU's instruction stream without fetching anything itself. The host prefetches code ahead of execution, so the order of bus fetches does not show when an instruction actually runs. The block therefore keeps a local byte queue that copies the host's prefetch queue. It fills the queue from observed code-fetch cycles. It removes bytes or empties the queue as the host's two queue-status outputs direct.

Whenever the host takes a first opcode byte with the escape pattern, the block remembers the low three bits of that byte. When the host then takes the following byte, the block combines the two bytes into a six-bit coprocessor opcode and the two addressing fields. It announces the result with a one-cycle strobe.

A strap input is sampled while reset is held. It selects either a 16-bit-bus host with a six-byte queue or an 8-bit-bus host with a four-byte queue.

Top module: `esc_queue_tracker`

## Requirements
- R1: While `rst` is high the queue is emptied, `dec_valid_o` is 0, and `host_wide_o` follows `host_sel_i`. After reset `host_wide_o` keeps the last value sampled during reset, whatever `host_sel_i` does later.
- R2: Queue capacity is 6 bytes when `host_wide_o`=1 and 4 bytes when it is 0. `q_level_o` never exceeds the capacity. Fetched bytes that do not fit in the free space are dropped. Free space is measured before any removal in the same cycle.
- R3: With `host_wide_o`=1, a fetch with `fetch_two_i`=1 enqueues `fetch_data_i[7:0]` and then `fetch_data_i[15:8]`. With `host_wide_o`=0, only `fetch_data_i[7:0]` is ever enqueued.
- R4: `qstat_i` encoding: 00 means no operation, 01 means the host took a first opcode byte, 10 means the host emptied its queue, and 11 means the host took a subsequent byte. Codes 01 and 11 remove the oldest byte. `q_level_o` updates one clock after the edge that samples the status.
- R5: Status 10 empties the queue, including bytes fetched in the same cycle. It also discards a half-assembled instruction.
- R6: A first byte is an escape when bits 7:3 equal 11011 (0xD8 to 0xDF).
- R7: When an escape first byte is followed by a subsequent-byte removal of byte B, `dec_valid_o` is high for exactly one cycle after that edge. In that cycle `dec_opcode_o` = {first[2:0], B[5:3]}, `dec_mod_o` = B[7:6] and `dec_rm_o` = B[2:0].
- R8: A non-escape first byte causes no strobe on any later subsequent-byte removal.
- R9: A removal status (01 or 11) with an empty queue changes neither the queue nor the pending instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_i | input | 1 | Host-type strap, sampled during reset (1 = 16-bit bus) |
| fetch_valid_i | input | 1 | A code-fetch cycle completes this clock |
| fetch_two_i | input | 1 | The fetch carries two bytes |
| fetch_data_i | input | 16 | Fetched code bytes, lower address in bits 7:0 |
| qstat_i | input | 2 | Host queue status |
| host_wide_o | output | 1 | Latched host type |
| q_level_o | output | $clog2(DEPTH_WIDE+1) | Local queue occupancy |
| dec_valid_o | output | 1 | Decoded-instruction strobe |
| dec_opcode_o | output | 6 | Coprocessor opcode |
| dec_mod_o | output | 2 | Addressing mod field |
| dec_rm_o | output | 3 | Addressing r/m field |

## Verification
A slipped read or write pointer shows up as a decoded opcode or r/m field built from the wrong byte. It appears on the first strobe after the slip, usually within a few cycles. A wrong occupancy count is visible on `q_level_o` one clock after the offending status or fetch. A lost or stale pending flag shows up as a missing or extra strobe one clock after the next subsequent-byte removal. The bench compares every cycle against a byte-level model, so each of these faults is caught at the first cycle it reaches a port.

// File: rtl/esc_qt_pkg.sv
package esc_qt_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  localparam logic [4:0] ESC_PATTERN = 5'b11011;

  typedef struct packed {
    logic [5:0] opcode;
    logic [1:0] mode;
    logic [2:0] rm;
  } esc_insn_t;

endpackage

// File: rtl/esc_host_mode.sv
module esc_host_mode (
  input  logic clk,
  input  logic rst,
  input  logic host_sel_i,
  output logic host_wide_o
);

  always_ff @(posedge clk) begin
    if (rst) host_wide_o <= host_sel_i;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(host_wide_o)); // R1

endmodule

// File: rtl/esc_byte_fifo.sv
module esc_byte_fifo #(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  localparam int PW = $clog2(DEPTH_WIDE),
  localparam int CW = $clog2(DEPTH_WIDE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_mode,
  input  logic          flush,
  input  logic          pop,
  input  logic          push_en,
  input  logic          push_two,
  input  logic [15:0]   push_data,
  output logic [7:0]    head_byte,
  output logic          head_valid,
  output logic [CW-1:0] level
);

  logic [7:0]    mem [DEPTH_WIDE];
  logic [PW-1:0] rd_ptr, wr_ptr, wr_ptr1, rd_next, lim_m1;
  logic [CW-1:0] limit, space, want, take;
  logic          do_pop;

  always_comb begin
    limit   = wide_mode ? CW'(DEPTH_WIDE) : CW'(DEPTH_NARROW);
    lim_m1  = PW'(limit - CW'(1));
    space   = limit - level;
    if (!push_en)                  want = '0;
    else if (push_two && wide_mode) want = CW'(2);
    else                           want = CW'(1);
    take    = (want > space) ? space : want;
    do_pop  = pop && (level != '0);
    wr_ptr1 = (wr_ptr == lim_m1) ? '0 : wr_ptr + PW'(1);
    rd_next = (rd_ptr == lim_m1) ? '0 : rd_ptr + PW'(1);
  end

  // storage: plain array, no reset
  always_ff @(posedge clk) begin
    if (!rst && !flush) begin
      if (take != '0)     mem[wr_ptr]  <= push_data[7:0];
      if (take == CW'(2)) mem[wr_ptr1] <= push_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_next;
      if (take == CW'(1))      wr_ptr <= wr_ptr1;
      else if (take == CW'(2)) wr_ptr <= (wr_ptr1 == lim_m1) ? '0 : wr_ptr1 + PW'(1);
      level <= level + take - (do_pop ? CW'(1) : CW'(0));
    end
  end

  assign head_byte  = mem[rd_ptr];
  assign head_valid = (level != '0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= limit); // R2
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> level == '0); // R5
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush && !push_en && level == '0) |=> level == '0); // R9
  AST_NARROW_ONE: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && push_en && !pop && !flush && level < limit)
      |=> level == $past(level) + CW'(1)); // R3

endmodule

// File: rtl/esc_decoder.sv
module esc_decoder
  import esc_qt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] qstat,
  input  logic [7:0] head_byte,
  input  logic      head_valid,
  output logic      dec_valid,
  output esc_insn_t dec_insn
);

  logic       pending;
  logic [2:0] first_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      first_low <= '0;
      dec_valid <= 1'b0;
      dec_insn  <= '0;
    end else begin
      dec_valid <= 1'b0;
      case (qstat)
        QS_FLUSH: pending <= 1'b0;
        QS_FIRST: if (head_valid) begin
          pending   <= (head_byte[7:3] == ESC_PATTERN);
          first_low <= head_byte[2:0];
        end
        QS_NEXT: if (head_valid && pending) begin
          dec_valid       <= 1'b1;
          dec_insn.opcode <= {first_low, head_byte[5:3]};
          dec_insn.mode   <= head_byte[7:6];
          dec_insn.rm     <= head_byte[2:0];
          pending         <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid); // R7
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(qstat) == QS_NEXT); // R7
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (qstat == QS_FLUSH) |=> !pending); // R5
  AST_NONESC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (qstat == QS_FIRST && head_valid && head_byte[7:3] != ESC_PATTERN) |=> !pending); // R8

endmodule

// File: rtl/esc_queue_tracker.sv
module esc_queue_tracker
  import esc_qt_pkg::*;
#(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  localparam int CW = $clog2(DEPTH_WIDE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel_i,
  input  logic          fetch_valid_i,
  input  logic          fetch_two_i,
  input  logic [15:0]   fetch_data_i,
  input  logic [1:0]    qstat_i,
  output logic          host_wide_o,
  output logic [CW-1:0] q_level_o,
  output logic          dec_valid_o,
  output logic [5:0]    dec_opcode_o,
  output logic [1:0]    dec_mod_o,
  output logic [2:0]    dec_rm_o
);

  logic      q_flush, q_pop, head_valid;
  logic [7:0] head_byte;
  esc_insn_t insn;

  assign q_flush = (qstat_i == QS_FLUSH);
  assign q_pop   = (qstat_i == QS_FIRST) || (qstat_i == QS_NEXT);

  esc_host_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .host_sel_i (host_sel_i),
    .host_wide_o(host_wide_o)
  );

  esc_byte_fifo #(
    .DEPTH_WIDE  (DEPTH_WIDE),
    .DEPTH_NARROW(DEPTH_NARROW)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (host_wide_o),
    .flush     (q_flush),
    .pop       (q_pop),
    .push_en   (fetch_valid_i),
    .push_two  (fetch_two_i),
    .push_data (fetch_data_i),
    .head_byte (head_byte),
    .head_valid(head_valid),
    .level     (q_level_o)
  );

  esc_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .qstat     (qstat_i),
    .head_byte (head_byte),
    .head_valid(head_valid),
    .dec_valid (dec_valid_o),
    .dec_insn  (insn)
  );

  assign dec_opcode_o = insn.opcode;
  assign dec_mod_o    = insn.mode;
  assign dec_rm_o     = insn.rm;

endmodule

// File: tb/esc_queue_tracker_tb.sv
`timescale 1ns/1ps
module esc_queue_tracker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b1;
  logic        fv = 1'b0, f2 = 1'b0;
  logic [15:0] fd = '0;
  logic [1:0]  qs = 2'b00;
  logic        host_wide, dvalid;
  logic [2:0]  level;
  logic [5:0]  dop;
  logic [1:0]  dmod;
  logic [2:0]  drm;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [7:0] mq[$];
  logic       m_wide = 1'b0, m_pend = 1'b0;
  logic [2:0] m_low = '0;

  always #5 clk = ~clk;

  esc_queue_tracker u_dut (
    .clk(clk), .rst(rst), .host_sel_i(host_sel),
    .fetch_valid_i(fv), .fetch_two_i(f2), .fetch_data_i(fd), .qstat_i(qs),
    .host_wide_o(host_wide), .q_level_o(level), .dec_valid_o(dvalid),
    .dec_opcode_o(dop), .dec_mod_o(dmod), .dec_rm_o(drm)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic is_esc(input logic [7:0] b);
    return b[7:3] == 5'b11011;
  endfunction

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst = 1'b1; host_sel = pin; fv = 0; f2 = 0; qs = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1", "level in reset", level, 0);
    chk("R1", "strobe in reset", dvalid, 0);
    chk("R1", "mode in reset", host_wide, pin);
    rst = 1'b0;
    mq.delete(); m_pend = 0; m_wide = pin;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic [1:0] s, input logic v,
                      input logic two, input logic [15:0] d);
    logic       ev;
    logic [5:0] eop;
    logic [1:0] emod;
    logic [2:0] erm;
    int pre, lim, space;
    logic [7:0] b;
    ev = 0; eop = '0; emod = '0; erm = '0;
    qs = s; fv = v; f2 = two; fd = d;
    @(posedge clk);
    lim = m_wide ? 6 : 4;
    if (s == 2'b10) begin
      mq.delete(); m_pend = 0;
    end else begin
      pre = mq.size();
      if ((s == 2'b01 || s == 2'b11) && pre > 0) begin
        b = mq.pop_front();
        if (s == 2'b01) begin
          m_pend = is_esc(b); m_low = b[2:0];
        end else if (m_pend) begin
          ev = 1; eop = {m_low, b[5:3]}; emod = b[7:6]; erm = b[2:0]; m_pend = 0;
        end
      end
      if (v) begin
        space = lim - pre;
        if (space >= 1) mq.push_back(d[7:0]);
        if (m_wide && two && space >= 2) mq.push_back(d[15:8]);
      end
    end
    @(negedge clk);
    qs = 2'b00; fv = 0; f2 = 0;
    chk(tag, "level", level, mq.size());
    chk(tag, "strobe", dvalid, ev);
    if (ev) begin
      chk(tag, "opcode", dop, eop);
      chk(tag, "mod", dmod, emod);
      chk(tag, "rm", drm, erm);
    end
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [1:0] s;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      if (r < 30) s = 2'b00; else if (r < 55) s = 2'b01;
      else if (r < 95) s = 2'b11; else s = 2'b10;
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) d[7:3] = 5'b11011;
      step("R4", s, ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1), d);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    // wide host
    do_reset(1'b1);
    host_sel = 1'b0;
    step("R1", 2'b00, 0, 0, 16'h0);
    chk("R1", "mode held after reset", host_wide, 1);
    // R6/R7 escape decode
    step("R3", 2'b00, 1, 1, 16'h5CD9);
    step("R7", 2'b01, 0, 0, 16'h0);
    step("R7", 2'b11, 0, 0, 16'h0);
    // R8 non-escape first byte
    step("R8", 2'b00, 1, 1, 16'h5C90);
    step("R8", 2'b01, 0, 0, 16'h0);
    step("R8", 2'b11, 0, 0, 16'h0);
    // R6 boundaries: 0xDF escape, 0xD7 not, 0xE0 not, 0xD8 escape
    step("R6", 2'b00, 1, 1, 16'hFFDF);
    step("R6", 2'b01, 0, 0, 16'h0);
    step("R6", 2'b11, 0, 0, 16'h0);
    chk("R6", "0xDF strobe opcode", dop, 6'b111111);
    step("R6", 2'b00, 1, 1, 16'h00D7);
    step("R6", 2'b01, 0, 0, 16'h0);
    step("R6", 2'b11, 0, 0, 16'h0);
    step("R6", 2'b00, 1, 1, 16'h00E0);
    step("R6", 2'b01, 0, 0, 16'h0);
    step("R6", 2'b11, 0, 0, 16'h0);
    step("R6", 2'b00, 1, 1, 16'h07D8);
    step("R6", 2'b01, 0, 0, 16'h0);
    step("R6", 2'b11, 0, 0, 16'h0);
    // R9 pops on empty
    step("R9", 2'b01, 0, 0, 16'h0);
    step("R9", 2'b11, 0, 0, 16'h0);
    // R2 fill wide queue: 8 bytes offered, 6 kept
    for (int i = 0; i < 4; i++) step("R2", 2'b00, 1, 1, 16'hD9D9);
    chk("R2", "wide capacity", level, 6);
    step("R2", 2'b11, 1, 1, 16'h1111);
    chk("R2", "space before pop", level, 5);
    // R5 flush with same-cycle fetch, and partial instruction dropped
    step("R5", 2'b10, 1, 1, 16'h2222);
    chk("R5", "flush level", level, 0);
    step("R5", 2'b00, 1, 0, 16'h00DA);
    step("R5", 2'b01, 0, 0, 16'h0);
    step("R5", 2'b10, 0, 0, 16'h0);
    step("R5", 2'b00, 1, 0, 16'h0033);
    step("R5", 2'b11, 0, 0, 16'h0);
    random_run(3000);
    // narrow host
    do_reset(1'b0);
    step("R3", 2'b00, 1, 1, 16'hAADB);
    chk("R3", "narrow takes one byte", level, 1);
    step("R3", 2'b00, 1, 1, 16'hDB6B);
    step("R3", 2'b01, 0, 0, 16'h0);
    step("R3", 2'b11, 0, 0, 16'h0);
    for (int i = 0; i < 5; i++) step("R2", 2'b00, 1, 1, 16'h1234);
    chk("R2", "narrow capacity", level, 4);
    random_run(3000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule